// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block models a 128-word by 16-bit serial EEPROM. A CPU drives it only by toggling pins. It writes chip-select, clock and data-in through one memory-mapped pin register, and it reads data-out back from the same register. The block finds the start bit, takes a 10-bit command that carries an opcode and a word address, and then reads, writes or erases one word, fills or erases every word, or sets or clears a write-enable flag. The words are held in an internal flop array.

The pin register can be reached only when two separate unlock writes have both been made. The unlocked register sits at offset 0x80 of the 0xA000 to 0xAFFF window. Its bit map is: bit 7 chip select, bit 6 clock, bit 1 data in, bit 0 data out. Each bus write to the register counts as one pin update. An edge on chip select or on the clock is found by comparing the new value with the value the register held before.

Top module: `serial_eeprom_emu`

## Requirements
- R1: After reset the pin register reads 0x01, writing is disabled, and every word reads back as 0xFFFF.
- R2: The pin register is reachable only while two flags are both set. One flag is set by writing 0x0A to 0x0000-0x1FFF. The other is set by writing 0x40 to 0x4000-0x5FFF. Writing any other value to the second range clears the second flag. Writing any value other than 0x0A to the first range clears both flags. While the register is locked, reads of it return 0xFF and writes to it change nothing.
- R3: A rising edge of chip select (bit 7) forces the protocol back to idle, even in the middle of a read-out.
- R4: In idle, a rising clock edge (bit 6) with data-in (bit 1) at 1 is a start bit. A rising edge with data-in at 0 is ignored.
- R5: After the start bit, 10 bits are shifted in MSB first. Bits 9:8 are the main opcode and bits 6:0 are the word address. Main opcode 10 is a read: data-out shows 0 on the decoding edge, then the word MSB first on the next 16 rising edges, and the protocol returns to idle after the sixteenth edge.
- R6: When the main opcode is 00, bits 7:6 choose a sub-operation: 00 disables writing, 11 enables writing, and both return to idle at once. Writing is disabled after reset. While it is disabled, write, erase, write-all and erase-all leave the storage unchanged.
- R7: Main opcode 01 shifts in 16 data bits MSB first and then stores them at the decoded address.
- R8: Main opcode 11 sets the addressed word to 0xFFFF on the decoding edge.
- R9: Sub-operation 01 shifts in 16 data bits and then writes them to all 128 words.
- R10: Sub-operation 10 sets all 128 words to 0xFFFF on the decoding edge.
- R11: On a falling clock edge while chip select is high, data-out keeps its previous value. After any other pin update that is not a rising clock edge, data-out reads 1.
- R12: When chip select and clock rise in the same write with data-in at 1, the protocol resets to idle and takes that same edge as a start bit.
- R13: The pin register decodes at addresses with bits 15:12 = 0xA and bits 7:4 = 0x8. Other addresses read 0xFF even when unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | One-cycle CPU write strobe |
| bus_addr_i | input | 16 | CPU address for the write or the read |
| bus_wdata_i | input | 8 | CPU write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |

## Verification
A single pin write can raise chip select and the clock together. Chip-select handling must then reset the protocol to idle before the clock handling runs, so that the same edge can start a new command. The bench first leaves the protocol part-way through a command. It then issues one write that raises both pins with data-in at 1, follows it with a read command, and judges the result by whether the returned word is correct. A second collision, chip select rising during a read-out, is judged by data-out going back to 1 on the next clock edge instead of carrying on with data bits.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned WORDS    = 128;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = $clog2(WORDS);
  localparam int unsigned CMD_BITS = 10;
  localparam int unsigned BITS_W   = $clog2(WORD_W + 1);

  localparam int unsigned PIN_CS  = 7;
  localparam int unsigned PIN_CLK = 6;
  localparam int unsigned PIN_DI  = 1;
  localparam int unsigned PIN_DO  = 0;

  localparam logic [7:0] PIN_RST  = 8'h01;
  localparam logic [7:0] KEY_OPEN = 8'h0A;
  localparam logic [7:0] KEY_ARM  = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WRITE,
    ST_WRALL,
    ST_SHOUT
  } eep_state_e;
endpackage

// File: rtl/eep_access_gate.sv
module eep_access_gate (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] region_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  import eep_pkg::*;

  logic open_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (we_i) begin
      if (region_i == 3'd0) begin
        if (wdata_i == KEY_OPEN) open_q <= 1'b1;
        else begin
          open_q <= 1'b0;
          arm_q  <= 1'b0;
        end
      end else if (region_i == 3'd2) begin
        arm_q <= (wdata_i == KEY_ARM);
      end
    end
  end

  assign open_o = open_q & arm_q;
endmodule

// File: rtl/eep_word_store.sv
module eep_word_store #(
  parameter int unsigned WORDS  = eep_pkg::WORDS,
  parameter int unsigned WORD_W = eep_pkg::WORD_W,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      if (all_i) begin
        for (int i = 0; i < WORDS; i++) mem_q[i] <= wdata_i;
      end else begin
        mem_q[addr_i] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eep_wire_fsm.sv
module eep_wire_fsm
  import eep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_we_i,
  input  logic [7:0]        pin_wdata_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [7:0]        pin_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_all_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output eep_state_e        state_o,
  output logic [BITS_W-1:0] bits_o,
  output logic              wen_o
);
  localparam int unsigned OP_HI = CMD_BITS - 1;

  eep_state_e        st_q, st_d, st_w;
  logic [7:0]        pin_q, pin_d;
  logic [WORD_W-1:0] sr_q, sr_d, sr_sh;
  logic [BITS_W-1:0] bits_q, bits_d, bits_inc;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wen_q, wen_d;
  logic              cs_rise, clk_rise, clk_fall, di;
  logic              cmd_done;

  assign di       = pin_wdata_i[PIN_DI];
  assign cs_rise  = !pin_q[PIN_CS] && pin_wdata_i[PIN_CS];
  assign clk_rise = !pin_q[PIN_CLK] && pin_wdata_i[PIN_CLK];
  assign clk_fall = pin_q[PIN_CLK] && !pin_wdata_i[PIN_CLK];
  assign st_w     = cs_rise ? ST_IDLE : st_q;
  assign sr_sh    = {sr_q[WORD_W-2:0], di};
  assign bits_inc = bits_q + 1'b1;
  assign cmd_done = pin_we_i && clk_rise && (st_w == ST_CMD) &&
                    (bits_inc == BITS_W'(CMD_BITS));

  // decoded address is visible to the store on the decoding edge
  always_comb begin
    addr_d = addr_q;
    if (cmd_done) addr_d = sr_sh[ADDR_W-1:0];
  end

  always_comb begin
    st_d        = st_q;
    pin_d       = pin_q;
    sr_d        = sr_q;
    bits_d      = bits_q;
    wen_d       = wen_q;
    mem_we_o    = 1'b0;
    mem_all_o   = 1'b0;
    mem_wdata_o = '1;
    if (pin_we_i) begin
      pin_d         = pin_wdata_i;
      pin_d[PIN_DO] = 1'b1;
      st_d          = st_w;
      if (clk_rise) begin
        unique case (st_w)
          ST_IDLE: if (di) begin
            st_d   = ST_CMD;
            sr_d   = '0;
            bits_d = '0;
          end
          ST_CMD: begin
            sr_d   = sr_sh;
            bits_d = bits_inc;
            if (cmd_done) begin
              bits_d = '0;
              st_d   = ST_IDLE;
              unique case (sr_sh[OP_HI -: 2])
                2'b01: st_d = ST_WRITE;
                2'b10: begin
                  sr_d          = mem_rdata_i;
                  bits_d        = BITS_W'(WORD_W);
                  st_d          = ST_SHOUT;
                  pin_d[PIN_DO] = 1'b0;
                end
                2'b11: mem_we_o = wen_q;
                default: begin
                  unique case (sr_sh[OP_HI-2 -: 2])
                    2'b00: wen_d = 1'b0;
                    2'b01: st_d  = ST_WRALL;
                    2'b10: begin
                      mem_we_o  = wen_q;
                      mem_all_o = 1'b1;
                    end
                    default: wen_d = 1'b1;
                  endcase
                end
              endcase
            end
          end
          ST_WRITE, ST_WRALL: begin
            sr_d   = sr_sh;
            bits_d = bits_inc;
            if (bits_inc == BITS_W'(WORD_W)) begin
              mem_we_o    = wen_q;
              mem_all_o   = (st_w == ST_WRALL);
              mem_wdata_o = sr_sh;
              st_d        = ST_IDLE;
            end
          end
          ST_SHOUT: begin
            pin_d[PIN_DO] = sr_q[WORD_W-1];
            sr_d          = {sr_q[WORD_W-2:0], 1'b0};
            bits_d        = bits_q - 1'b1;
            if (bits_q == BITS_W'(1)) st_d = ST_IDLE;
          end
          default: st_d = ST_IDLE;
        endcase
      end else if (pin_wdata_i[PIN_CS] && clk_fall) begin
        pin_d[PIN_DO] = pin_q[PIN_DO];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pin_q  <= PIN_RST;
      sr_q   <= '0;
      bits_q <= '0;
      addr_q <= '0;
      wen_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pin_q  <= pin_d;
      sr_q   <= sr_d;
      bits_q <= bits_d;
      addr_q <= addr_d;
      wen_q  <= wen_d;
    end
  end

  assign pin_o      = pin_q;
  assign mem_addr_o = addr_d;
  assign state_o    = st_q;
  assign bits_o     = bits_q;
  assign wen_o      = wen_q;
endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu
  import eep_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [15:0] bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o
);
  logic              access_ok;
  logic              pin_hit;
  logic              pin_we;
  logic [7:0]        pin_q;
  logic [ADDR_W-1:0] store_addr;
  logic              store_we, store_all;
  logic [WORD_W-1:0] store_wdata, store_rdata;
  eep_state_e        fsm_state;
  logic [BITS_W-1:0] fsm_bits;
  logic              fsm_wen;
  logic              unused_addr_bits;

  assign pin_hit = (bus_addr_i[15:12] == 4'hA) && (bus_addr_i[7:4] == 4'h8);
  assign pin_we  = bus_we_i && pin_hit && access_ok;
  assign unused_addr_bits = ^{bus_addr_i[11:8], bus_addr_i[3:0]};

  eep_access_gate i_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .region_i (bus_addr_i[15:13]),
    .wdata_i  (bus_wdata_i),
    .open_o   (access_ok)
  );

  eep_wire_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_we_i    (pin_we),
    .pin_wdata_i (bus_wdata_i),
    .mem_rdata_i (store_rdata),
    .pin_o       (pin_q),
    .mem_addr_o  (store_addr),
    .mem_we_o    (store_we),
    .mem_all_o   (store_all),
    .mem_wdata_o (store_wdata),
    .state_o     (fsm_state),
    .bits_o      (fsm_bits),
    .wen_o       (fsm_wen)
  );

  eep_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (store_we),
    .all_i   (store_all),
    .addr_i  (store_addr),
    .wdata_i (store_wdata),
    .rdata_o (store_rdata)
  );

  assign bus_rdata_o = (access_ok && pin_hit) ? pin_q : 8'hFF;
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [15:0]       bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic [7:0]        bus_rdata_o,
  input  logic [7:0]        pin_q_i,
  input  logic              access_ok_i,
  input  eep_state_e        state_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic              wen_i,
  input  logic              store_we_i
);
  logic pw, c_rise, k_rise, k_fall;
  assign pw     = bus_we_i && access_ok_i && (bus_addr_i[15:12] == 4'hA) &&
                  (bus_addr_i[7:4] == 4'h8);
  assign c_rise = !pin_q_i[PIN_CS] && bus_wdata_i[PIN_CS];
  assign k_rise = !pin_q_i[PIN_CLK] && bus_wdata_i[PIN_CLK];
  assign k_fall = pin_q_i[PIN_CLK] && !bus_wdata_i[PIN_CLK];

  AST_LOCKED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o != 8'hFF) |-> access_ok_i); // R2

  AST_CS_RISE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw && c_rise && !k_rise) |=> (state_i == ST_IDLE)); // R3

  AST_DO_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw && !k_rise && !(bus_wdata_i[PIN_CS] && k_fall)) |=> pin_q_i[PIN_DO]); // R11

  AST_DO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw && bus_wdata_i[PIN_CS] && k_fall) |=> $stable(pin_q_i[PIN_DO])); // R11

  AST_BIT_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_i <= BITS_W'(WORD_W)); // R5

  AST_STORE_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we_i |-> wen_i); // R6
endmodule

bind serial_eeprom_emu eep_checker i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_q_i     (pin_q),
  .access_ok_i (access_ok),
  .state_i     (fsm_state),
  .bits_i      (fsm_bits),
  .wen_i       (fsm_wen),
  .store_we_i  (store_we)
);

// File: tb/test_serial_eeprom_emu.sv
`timescale 1ns/100ps
module test_serial_eeprom_emu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic [7:0]  rdata;
  int checks = 0;
  int failures = 0;

  localparam logic [15:0] PIN_ADDR = 16'hA080;
  localparam int NVEC = 6;
  localparam logic [22:0] VEC_TAB [NVEC] = '{
    {7'd0,   16'h1234}, {7'd1,  16'h8001}, {7'd2, 16'hFFFE},
    {7'd127, 16'h0001}, {7'd64, 16'hA5C3}, {7'd2, 16'h0000}
  };

  always #2.5 clk = ~clk;

  serial_eeprom_emu i_serial_eeprom_emu (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pin_wr(input logic cs, input logic ck, input logic di);
    bus_wr(PIN_ADDR, {cs, ck, 4'b0, di, 1'b0});
  endtask

  task automatic rd_do(output logic b);
    logic [7:0] v;
    bus_rd(PIN_ADDR, v);
    b = v[0];
  endtask

  task automatic send_bit(input logic di);
    pin_wr(1'b1, 1'b0, di);
    pin_wr(1'b1, 1'b1, di);
  endtask

  task automatic begin_tx();
    pin_wr(1'b0, 1'b0, 1'b0);
    pin_wr(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send_bits10(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_cmd(input logic [9:0] c);
    begin_tx();
    send_bit(1'b1);
    send_bits10(c);
  endtask

  task automatic send_word(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  // read command bits then 16 data edges; checks DO hold on each falling edge
  task automatic read_tail(input logic [6:0] a, output logic dummy,
                           output logic [15:0] d, output int hold_err);
    logic prev, b;
    hold_err = 0;
    send_bits10({2'b10, 1'b0, a});
    rd_do(dummy);
    prev = dummy;
    d = '0;
    for (int i = 0; i < 16; i++) begin
      pin_wr(1'b1, 1'b0, 1'b0);
      rd_do(b);
      if (b !== prev) hold_err++;
      pin_wr(1'b1, 1'b1, 1'b0);
      rd_do(b);
      d = {d[14:0], b};
      prev = b;
    end
  endtask

  task automatic read_word(input logic [6:0] a, output logic [15:0] d);
    logic dm; int he;
    begin_tx();
    send_bit(1'b1);
    read_tail(a, dm, d, he);
  endtask

  task automatic write_word(input logic [6:0] a, input logic [15:0] d);
    send_cmd({2'b01, 1'b0, a});
    send_word(d);
  endtask

  task automatic cmd_ewen(); send_cmd({4'b0011, 6'b0}); endtask
  task automatic cmd_ewds(); send_cmd({4'b0000, 6'b0}); endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] w;
    logic        dm, b;
    int          he;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    bus_rd(PIN_ADDR, v);
    chk("R2 locked after reset", v, 8'hFF);
    bus_wr(16'h0000, 8'h0A);
    bus_wr(16'h4000, 8'h40);
    bus_rd(PIN_ADDR, v);
    chk("R1 pin reset value", v, 8'h01);

    write_word(7'd5, 16'hAAAA);
    read_word(7'd5, w);
    chk("R1/R6 write disabled after reset", w, 16'hFFFF);

    cmd_ewen();
    for (int k = 0; k < NVEC; k++) begin
      write_word(VEC_TAB[k][22:16], VEC_TAB[k][15:0]);
      read_word(VEC_TAB[k][22:16], w);
      chk("R7 write then read", w, VEC_TAB[k][15:0]);
    end

    // R5: dummy zero, MSB-first read, falling-edge hold (R11)
    begin_tx();
    send_bit(1'b1);
    read_tail(7'd64, dm, w, he);
    chk("R5 dummy zero bit", dm, 1'b0);
    chk("R5 read data MSB first", w, 16'hA5C3);
    chk("R11 DO held on falling clock", he, 0);
    pin_wr(1'b1, 1'b0, 1'b0);
    pin_wr(1'b1, 1'b1, 1'b0);
    rd_do(b);
    chk("R5 idle after 16 bits, DO undriven", b, 1'b1);

    // R11: last bit of 0x1234 is 0; falling clock with CS low releases DO
    begin_tx();
    send_bit(1'b1);
    read_tail(7'd0, dm, w, he);
    chk("R11 read for release test", w, 16'h1234);
    pin_wr(1'b0, 1'b0, 1'b0);
    rd_do(b);
    chk("R11 DO reads 1 with CS low", b, 1'b1);

    // R4: zeros before the start bit are ignored
    begin_tx();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1);
    read_tail(7'd1, dm, w, he);
    chk("R4 leading zeros ignored", w, 16'h8001);

    // R3: CS rising during read-out forces idle (word 2 is 0x0000)
    begin_tx();
    send_bit(1'b1);
    send_bits10({2'b10, 1'b0, 7'd2});
    send_bit(1'b0);
    rd_do(b);
    chk("R3 first data bit", b, 1'b0);
    pin_wr(1'b0, 1'b0, 1'b0);
    pin_wr(1'b1, 1'b0, 1'b0);
    pin_wr(1'b1, 1'b1, 1'b0);
    rd_do(b);
    chk("R3 read-out aborted by CS rise", b, 1'b1);

    // R12: CS and clock rise together with DI=1 while mid-command
    begin_tx();
    send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    pin_wr(1'b0, 1'b0, 1'b0);
    pin_wr(1'b1, 1'b1, 1'b1);
    read_tail(7'd127, dm, w, he);
    chk("R12 combined CS/clock start", w, 16'h0001);

    // R8 erase
    send_cmd({2'b11, 1'b0, 7'd1});
    read_word(7'd1, w);
    chk("R8 erase word", w, 16'hFFFF);
    read_word(7'd0, w);
    chk("R8 neighbour untouched", w, 16'h1234);

    // R9 write-all
    send_cmd({4'b0001, 6'b0});
    send_word(16'h5A5A);
    read_word(7'd0, w);
    chk("R9 fill word 0", w, 16'h5A5A);
    read_word(7'd127, w);
    chk("R9 fill word 127", w, 16'h5A5A);

    // R10 erase-all
    send_cmd({4'b0010, 6'b0});
    read_word(7'd64, w);
    chk("R10 erase-all", w, 16'hFFFF);

    // R2: gated writes are ignored (writing is enabled here)
    bus_wr(16'h0000, 8'h00);
    bus_rd(PIN_ADDR, v);
    chk("R2 cleared by 0x00", v, 8'hFF);
    bus_wr(16'h0000, 8'h0A);
    bus_rd(PIN_ADDR, v);
    chk("R2 one flag not enough", v, 8'hFF);
    write_word(7'd6, 16'h1111);
    bus_wr(16'h4000, 8'h40);
    read_word(7'd6, w);
    chk("R2 locked writes ignored", w, 16'hFFFF);
    bus_wr(16'h0000, 8'h05);
    bus_wr(16'h0000, 8'h0A);
    bus_rd(PIN_ADDR, v);
    chk("R2 other value clears both", v, 8'hFF);
    bus_wr(16'h4000, 8'h40);
    bus_wr(16'h4000, 8'h41);
    bus_rd(PIN_ADDR, v);
    chk("R2 other arm value clears", v, 8'hFF);
    bus_wr(16'h4000, 8'h40);

    // R6 disable writing
    cmd_ewds();
    write_word(7'd9, 16'h1234);
    read_word(7'd9, w);
    chk("R6 write after disable", w, 16'hFFFF);
    cmd_ewen();
    write_word(7'd9, 16'h4321);
    read_word(7'd9, w);
    chk("R6 write after re-enable", w, 16'h4321);

    // R13 other offsets
    bus_rd(16'hA000, v);
    chk("R13 other offset reads FF", v, 8'hFF);
    bus_rd(16'hA085, v);
    chk("R13 pin register alias", v[7:6], 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule